// File: doc/BRIEF.md
# Posit Operand Field Decoder

This block takes one raw posit word of `NBITS` bits, with an exponent field of `ES` bits, and breaks it into the pieces that an arithmetic datapath needs. It returns the sign, the signed regime value, the exponent bits and the fraction. The fraction comes out with its hidden leading one made explicit. It also folds regime and exponent into one signed scale factor. Two flags mark the two special encodings, zero and not-a-real, so that later stages can bypass the arithmetic for them. The default format is an 8-bit word with a 1-bit exponent field.

A negative word is first replaced by its two's complement, and the magnitude is then decoded. The regime is a run of equal bits of variable length. The decoder measures the run, skips the bit that ends it, and reads the exponent and fraction bits from what is left of the word. Exponent and fraction bits that fall past the end of the word read as zero.

A parameter `REG_OUT` puts an output register after the decoder, so that the block can sit in one pipeline stage. The register loads only when the input is valid, and a valid bit follows it. With `REG_OUT = 0` the block is purely combinational.

Top module: `posit_decoder`

## Requirements
- R1: The all-zeros word raises `out_zero`. It also drives `out_sign`, `out_regime`, `out_exp`, `out_frac` and `out_scale` to 0.
- R2: A word with a 1 in the MSB and zeros everywhere else raises `out_nar`. It drives `out_sign` to 1 and `out_regime`, `out_exp`, `out_frac` and `out_scale` to 0.
- R3: `out_zero` and `out_nar` are never high together, and both stay low for every other word.
- R4: `out_sign` equals the input MSB. When the MSB is 1, the word is replaced by its NBITS-bit two's complement before any field is decoded.
- R5: The regime starts at the bit below the sign. It is a run of equal bits that ends at the first opposite bit or at the end of the word. A run of m zeros gives k = -m, and a run of m ones gives k = m-1. `out_regime` carries k in two's complement, with width clog2(NBITS)+1.
- R6: `out_exp` holds the ES bits that follow the regime's ending bit, the first of them in the MSB. Bits past the end of the word read as 0.
- R7: `out_frac` is NBITS-ES-2 bits wide. Its MSB is the hidden bit, set to 1 for every word that is neither zero nor not-a-real. Below the hidden bit, the remaining word bits follow in order, left-aligned and padded with zeros.
- R8: `out_scale` equals k*2^ES + `out_exp`, as a two's-complement signed value.
- R9: With `REG_OUT = 1`, a word sampled with `in_valid` high shows its decoded fields one clock later, and `out_valid` is `in_valid` delayed by one clock.
- R10: With `REG_OUT = 1`, a clock edge with `in_valid` low leaves every data output unchanged.
- R11: A synchronous reset clears `out_valid` and every data output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_word | input | NBITS | Raw posit word |
| out_valid | output | 1 | Decoded fields are valid |
| out_sign | output | 1 | Sign of the operand |
| out_zero | output | 1 | Operand is zero |
| out_nar | output | 1 | Operand is not-a-real |
| out_regime | output | clog2(NBITS)+1 | Signed regime value k |
| out_exp | output | max(ES,1) | Exponent bits |
| out_frac | output | NBITS-ES-2 | Fraction with explicit hidden bit |
| out_scale | output | clog2((NBITS-1)*2^ES)+1 | Signed combined scale |

## Verification
The hardest cases to reach are the ones where the regime run reaches the last bit of the word. In those cases there is no ending bit, and the exponent and fraction must be padded with zeros. A negative word that lands on such a magnitude after the two's complement is harder still. Random stimulus hits these few encodings rarely, so the bench also walks every word of the default 8-bit format and adds directed extremes, such as the largest and smallest magnitudes of both signs. It also applies idle cycles that carry a different word, to show that the held outputs do not move.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    localparam int DEF_NBITS = 8;
    localparam int DEF_ES    = 1;

    typedef enum logic [1:0] {
        PCLS_REAL = 2'd0,
        PCLS_ZERO = 2'd1,
        PCLS_NAR  = 2'd2
    } pclass_e;

    function automatic int frac_bits(input int n, input int es);
        return n - es - 3;
    endfunction

    function automatic int regime_width(input int n);
        return $clog2(n) + 1;
    endfunction

    function automatic int run_width(input int n);
        return $clog2(n);
    endfunction

    function automatic int scale_width(input int n, input int es);
        return $clog2((n - 1) << es) + 1;
    endfunction

    function automatic int exp_width(input int es);
        return (es > 0) ? es : 1;
    endfunction

endpackage

// File: rtl/posit_abs_stage.sv
module posit_abs_stage
    import posit_dec_pkg::*;
#(
    parameter int NBITS = DEF_NBITS
) (
    input  logic [NBITS-1:0] word,
    output logic             sign,
    output logic [NBITS-2:0] body,
    output pclass_e          cls
);
    localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] mag;

    always_comb begin
        sign = word[NBITS-1];
        mag  = sign ? (~word + {{(NBITS-1){1'b0}}, 1'b1}) : word;
        body = mag[NBITS-2:0];
        if (word == '0)
            cls = PCLS_ZERO;
        else if (word == NAR_WORD)
            cls = PCLS_NAR;
        else
            cls = PCLS_REAL;
    end
endmodule

// File: rtl/posit_regime_scan.sv
module posit_regime_scan
    import posit_dec_pkg::*;
#(
    parameter int NBITS = DEF_NBITS
) (
    input  logic [NBITS-2:0]                        body,
    output logic signed [regime_width(NBITS)-1:0]   k,
    output logic [run_width(NBITS)-1:0]             consumed
);
    localparam int KW = regime_width(NBITS);
    localparam int MW = run_width(NBITS);

    logic          lead;
    logic          ended;
    logic [MW-1:0] run;

    always_comb begin
        lead  = body[NBITS-2];
        run   = '0;
        ended = 1'b0;
        for (int i = NBITS - 2; i >= 0; i--) begin
            if (!ended) begin
                if (body[i] == lead)
                    run = run + MW'(1);
                else
                    ended = 1'b1;
            end
        end
        consumed = ended ? (run + MW'(1)) : run;
        if (lead)
            k = KW'(run) - KW'(1);
        else
            k = -KW'(run);
    end
endmodule

// File: rtl/posit_field_extract.sv
module posit_field_extract
    import posit_dec_pkg::*;
#(
    parameter int NBITS = DEF_NBITS,
    parameter int ES    = DEF_ES
) (
    input  logic [NBITS-2:0]                        body,
    input  logic [run_width(NBITS)-1:0]             consumed,
    input  logic signed [regime_width(NBITS)-1:0]   k,
    output logic [exp_width(ES)-1:0]                expo,
    output logic [frac_bits(NBITS, ES):0]           frac,
    output logic [scale_width(NBITS, ES)-1:0]       scale
);
    localparam int FW = frac_bits(NBITS, ES);
    localparam int SW = scale_width(NBITS, ES);
    localparam int EW = exp_width(ES);

    logic [NBITS-2:0] rest;
    logic [SW-1:0]    k_ext;

    assign rest = body << consumed;

    generate
        if (ES > 0) begin : g_exp
            assign expo = rest[NBITS-2 -: ES];
        end else begin : g_noexp
            assign expo = '0;
        end
    endgenerate

    assign frac  = {1'b1, rest[NBITS-2-ES -: FW]};
    assign k_ext = SW'(k);
    assign scale = (k_ext << ES) + SW'(expo);

    logic unused_ok;
    assign unused_ok = ^{EW};
endmodule

// File: rtl/posit_decoder.sv
module posit_decoder
    import posit_dec_pkg::*;
#(
    parameter int NBITS   = DEF_NBITS,
    parameter int ES      = DEF_ES,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic [NBITS-1:0]                    in_word,
    output logic                                out_valid,
    output logic                                out_sign,
    output logic                                out_zero,
    output logic                                out_nar,
    output logic [regime_width(NBITS)-1:0]      out_regime,
    output logic [exp_width(ES)-1:0]            out_exp,
    output logic [frac_bits(NBITS, ES):0]       out_frac,
    output logic [scale_width(NBITS, ES)-1:0]   out_scale
);
    localparam int FW = frac_bits(NBITS, ES);
    localparam int KW = regime_width(NBITS);
    localparam int MW = run_width(NBITS);
    localparam int SW = scale_width(NBITS, ES);
    localparam int EW = exp_width(ES);

    logic                 a_sign;
    logic [NBITS-2:0]     a_body;
    pclass_e              a_cls;
    logic signed [KW-1:0] r_k;
    logic [MW-1:0]        r_consumed;
    logic [EW-1:0]        f_exp;
    logic [FW:0]          f_frac;
    logic [SW-1:0]        f_scale;

    posit_abs_stage #(.NBITS(NBITS)) u_abs (
        .word (in_word),
        .sign (a_sign),
        .body (a_body),
        .cls  (a_cls)
    );

    posit_regime_scan #(.NBITS(NBITS)) u_scan (
        .body     (a_body),
        .k        (r_k),
        .consumed (r_consumed)
    );

    posit_field_extract #(.NBITS(NBITS), .ES(ES)) u_extract (
        .body     (a_body),
        .consumed (r_consumed),
        .k        (r_k),
        .expo     (f_exp),
        .frac     (f_frac),
        .scale    (f_scale)
    );

    // Special words mask every numeric field to zero.
    logic          c_real;
    logic          c_zero;
    logic          c_nar;
    logic [KW-1:0] c_regime;
    logic [EW-1:0] c_exp;
    logic [FW:0]   c_frac;
    logic [SW-1:0] c_scale;

    always_comb begin
        c_real   = (a_cls == PCLS_REAL);
        c_zero   = (a_cls == PCLS_ZERO);
        c_nar    = (a_cls == PCLS_NAR);
        c_regime = c_real ? r_k     : '0;
        c_exp    = c_real ? f_exp   : '0;
        c_frac   = c_real ? f_frac  : '0;
        c_scale  = c_real ? f_scale : '0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid  <= 1'b0;
                    out_sign   <= 1'b0;
                    out_zero   <= 1'b0;
                    out_nar    <= 1'b0;
                    out_regime <= '0;
                    out_exp    <= '0;
                    out_frac   <= '0;
                    out_scale  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_sign   <= a_sign;
                        out_zero   <= c_zero;
                        out_nar    <= c_nar;
                        out_regime <= c_regime;
                        out_exp    <= c_exp;
                        out_frac   <= c_frac;
                        out_scale  <= c_scale;
                    end
                end
            end
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_sign   = a_sign;
            assign out_zero   = c_zero;
            assign out_nar    = c_nar;
            assign out_regime = c_regime;
            assign out_exp    = c_exp;
            assign out_frac   = c_frac;
            assign out_scale  = c_scale;
            logic unused_clk;
            assign unused_clk = clk ^ rst;
        end
    endgenerate
endmodule

// File: rtl/posit_decoder_chk.sv
module posit_decoder_chk
    import posit_dec_pkg::*;
#(
    parameter int NBITS   = DEF_NBITS,
    parameter int ES      = DEF_ES,
    parameter bit REG_OUT = 1'b1
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                in_valid,
    input logic [NBITS-1:0]                    in_word,
    input logic                                out_valid,
    input logic                                out_sign,
    input logic                                out_zero,
    input logic                                out_nar,
    input logic [regime_width(NBITS)-1:0]      out_regime,
    input logic [exp_width(ES)-1:0]            out_exp,
    input logic [frac_bits(NBITS, ES):0]       out_frac,
    input logic [scale_width(NBITS, ES)-1:0]   out_scale
);
    localparam int FW        = frac_bits(NBITS, ES);
    localparam int SCALE_MIN = -((NBITS - 2) << ES);
    localparam int SCALE_MAX = ((NBITS - 2) << ES) + (1 << ES) - 1;
    localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};

    // R3: the two special flags never coincide
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(out_zero && out_nar));

    // R1: zero carries no numeric content
    p_zero_fields_r1: assert property (@(posedge clk) disable iff (rst)
        out_zero |-> (!out_sign && out_scale == '0 && out_frac == '0 && out_regime == '0));

    // R2: not-a-real is negative and carries no numeric content
    p_nar_fields_r2: assert property (@(posedge clk) disable iff (rst)
        out_nar |-> (out_sign && out_scale == '0 && out_frac == '0 && out_exp == '0));

    // R7: ordinary values carry the hidden one
    p_hidden_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero && !out_nar) |-> out_frac[FW]);

    // R8: scale stays within the range the format can express
    p_scale_range_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_scale) >= SCALE_MIN && $signed(out_scale) <= SCALE_MAX));

    generate
        if (REG_OUT) begin : g_seq
            // R9: valid follows the input by one clock
            p_valid_latency_r9: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_idle_latency_r9: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);

            // R4: sign follows the sampled MSB
            p_sign_follow_r4: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (out_sign == $past(in_word[NBITS-1])));

            // R1: a zero word is flagged
            p_zero_in_r1: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_word == '0) |=> out_zero);

            // R2: the not-a-real word is flagged
            p_nar_in_r2: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_word == NAR_WORD) |=> out_nar);

            // R10: idle cycles hold the data outputs
            p_hold_r10: assert property (@(posedge clk) disable iff (rst)
                (!in_valid && !$past(rst)) |=> ($stable(out_scale) && $stable(out_frac)
                    && $stable(out_sign) && $stable(out_zero) && $stable(out_nar)));
        end
    endgenerate
endmodule

bind posit_decoder posit_decoder_chk #(
    .NBITS   (NBITS),
    .ES      (ES),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_sign   (out_sign),
    .out_zero   (out_zero),
    .out_nar    (out_nar),
    .out_regime (out_regime),
    .out_exp    (out_exp),
    .out_frac   (out_frac),
    .out_scale  (out_scale)
);

// File: tb/tb_posit_decoder.sv
`timescale 1ns/1ps
module tb_posit_decoder;
    localparam int N  = 8;
    localparam int ES = 1;
    localparam int FW = N - ES - 3;
    localparam int KW = $clog2(N) + 1;
    localparam int EW = (ES > 0) ? ES : 1;
    localparam int SW = $clog2((N - 1) << ES) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_word = '0;
    logic          out_valid, out_sign, out_zero, out_nar;
    logic [KW-1:0] out_regime;
    logic [EW-1:0] out_exp;
    logic [FW:0]   out_frac;
    logic [SW-1:0] out_scale;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    posit_decoder #(.NBITS(N), .ES(ES), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_sign(out_sign), .out_zero(out_zero),
        .out_nar(out_nar), .out_regime(out_regime), .out_exp(out_exp),
        .out_frac(out_frac), .out_scale(out_scale)
    );

    task automatic chk(input string req, input int got, input int want, input logic [N-1:0] w);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s word=%h actual=%0d expected=%0d", req, w, got, want);
        end
    endtask

    // Expected fields worked out from the requirements with integer arithmetic.
    task automatic model(input logic [N-1:0] w, output int sg, output int zf, output int nf,
                         output int k, output int e, output int f, output int sc);
        int mag, pos, lead, m;
        sg = int'(w[N-1]);
        zf = (w == 0) ? 1 : 0;
        nf = (int'(w) == (1 << (N - 1))) ? 1 : 0;
        k = 0; e = 0; f = 0; sc = 0;
        if (zf == 0 && nf == 0) begin
            mag  = (sg == 1) ? (((1 << N) - int'(w)) % (1 << N)) : int'(w);
            pos  = N - 2;
            lead = (mag >> pos) & 1;
            m    = 0;
            while (pos >= 0 && ((mag >> pos) & 1) == lead) begin
                m++;
                pos--;
            end
            if (pos >= 0) pos--;
            k = (lead == 1) ? (m - 1) : -m;
            for (int j = 0; j < ES; j++) begin
                e = e * 2 + ((pos >= 0) ? ((mag >> pos) & 1) : 0);
                pos--;
            end
            f = 1;
            for (int j = 0; j < FW; j++) begin
                f = f * 2 + ((pos >= 0) ? ((mag >> pos) & 1) : 0);
                pos--;
            end
            sc = k * (1 << ES) + e;
        end
    endtask

    task automatic check_outputs(input logic [N-1:0] w);
        int sg, zf, nf, k, e, f, sc;
        model(w, sg, zf, nf, k, e, f, sc);
        chk("R9 out_valid", int'(out_valid), 1, w);
        chk("R1 out_zero", int'(out_zero), zf, w);
        chk("R2 out_nar", int'(out_nar), nf, w);
        chk("R3 flag pair", int'(out_zero & out_nar), 0, w);
        chk("R4 out_sign", int'(out_sign), sg, w);
        chk("R5 out_regime", int'($signed(out_regime)), k, w);
        chk("R6 out_exp", int'(out_exp), e, w);
        chk("R7 out_frac", int'(out_frac), f, w);
        chk("R8 out_scale", int'($signed(out_scale)), sc, w);
    endtask

    task automatic apply(input logic [N-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        check_outputs(w);
    endtask

    initial begin
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 out_valid", int'(out_valid), 0, in_word);
        chk("R11 out_scale", int'(out_scale), 0, in_word);
        chk("R11 out_frac", int'(out_frac), 0, in_word);
        chk("R11 flags", int'({out_sign, out_zero, out_nar}), 0, in_word);
        rst = 1'b0;

        // Directed corners: R1 R2 special words, R5 R6 runs to the word end, R4 negatives
        apply(8'h00);
        apply(8'h80);
        apply(8'h7F);
        apply(8'h01);
        apply(8'h81);
        apply(8'hFF);
        apply(8'h40);
        apply(8'hC0);
        apply(8'h7E);
        apply(8'h02);

        // Every word of the format
        for (int i = 0; i < (1 << N); i++) apply(N'(i));

        // R10: idle cycles with a different word must not disturb held outputs
        for (int i = 0; i < 20; i++) begin
            logic [N-1:0] w;
            w = N'($urandom);
            apply(w);
            @(negedge clk);
            in_word = ~w;
            @(negedge clk);
            chk("R10 out_valid low", int'(out_valid), 0, w);
            check_outputs_hold(w);
        end

        // Random back-to-back stream
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] w;
            w = N'($urandom);
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = w;
            @(negedge clk);
            check_outputs(w);
        end
        in_valid = 1'b0;

        // R11: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 reset valid", int'(out_valid), 0, in_word);
        chk("R11 reset scale", int'(out_scale), 0, in_word);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check_outputs_hold(input logic [N-1:0] w);
        int sg, zf, nf, k, e, f, sc;
        model(w, sg, zf, nf, k, e, f, sc);
        chk("R10 held scale", int'($signed(out_scale)), sc, w);
        chk("R10 held frac", int'(out_frac), f, w);
        chk("R10 held sign", int'(out_sign), sg, w);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule